// File: doc/BRIEF.md
# Dual-Unit Watchdog Countdown Timer

This block is a watchdog timer with a reload value of up to 16 bits. A host writes four byte-wide registers: control, configuration, and the low and high halves of the reload value. The counter counts down either once per second or once per minute. The unit is chosen by a configuration bit. In minute mode the block divides its one-second reference pulse by sixty.

While the timer runs, activity from an enabled peripheral source reloads the count. The sources are a gameport read, a consumer-IR interrupt, a mouse interrupt and a keyboard interrupt. When the count reaches zero, the block sets a sticky zero flag. It can also fire a keyboard-reset pulse, a power-good reset pulse and a one-cycle timeout event. With all three outputs disabled, the block runs in a test mode where expiry only records the flag. Software can also force an expiry.

Top module: `wdog_dual_unit`

## Requirements
- R1: The registers sit at REG_BASE+0 (control), +1 (configuration), +2 (reload low byte) and +3 (reload high byte). With the default base these are 0x71 to 0x74. Control layout: bit7 enables the consumer-IR source, bit6 the mouse source, bit5 the keyboard source, bit4 the gameport source; bit1 forces expiry; bit0 is the zero flag; bits 3:2 read 0. Configuration layout: bit7 selects seconds (1) or minutes (0), bit6 enables the keyboard reset, bit5 enables the timeout event, bit4 enables the power-good reset, and bits 3:0 hold an interrupt route. The configuration and reload registers read back what was written. After reset, every register and output reads 0.
- R2: A write to either reload byte loads the counter with the combined reload value in the next cycle. A nonzero value arms the timer. A zero value stops it.
- R3: With configuration bit7 set, a running count drops by one on each one-second tick.
- R4: With configuration bit7 clear, a running count drops by one on every sixtieth tick counted since the last load or reload.
- R5: While the timer runs, a pulse from a source whose control enable bit is set reloads the count with the reload value. A pulse from a source whose enable bit is clear has no effect.
- R6: When the count reaches zero, it stays at zero, the timer stops and control bit0 becomes 1. Writing the control register with bit0 = 0 clears the flag. Writing bit0 = 1 does not set it.
- R7: If configuration bit6 was set at expiry, kbd_rst_o goes high in the cycle after expiry for exactly RST_CYCLES cycles. If configuration bit4 was set, pwr_rst_o does the same.
- R8: If configuration bit5 was set at expiry, tmo_evt_o is high for exactly one cycle after expiry.
- R9: With configuration bits 6, 5 and 4 all clear, expiry only sets the zero flag. All three outputs stay low.
- R10: Writing control bit1 = 1 causes an expiry on the following clock, with the same effects as a natural expiry. The force bit then reads 0 again.
- R11: While the timer is stopped, neither keepalive pulses nor ticks change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Register address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for addr |
| sec_tick | input | 1 | One-cycle pulse once per second |
| gp_read | input | 1 | Gameport read keepalive pulse |
| cir_irq | input | 1 | Consumer-IR interrupt keepalive pulse |
| mouse_irq | input | 1 | Mouse interrupt keepalive pulse |
| kbd_irq | input | 1 | Keyboard interrupt keepalive pulse |
| kbd_rst_o | output | 1 | Keyboard reset pulse |
| pwr_rst_o | output | 1 | Power-good reset pulse |
| tmo_evt_o | output | 1 | One-cycle timeout event |
| count_o | output | CNT_W | Current count |
| running_o | output | 1 | Timer armed and counting |

## Verification
A table of reload values and tick counts drives the timer in both units.

- Runs stopped just short of zero and runs stopped exactly at zero separate counting from expiry.
- A run of 59 minute-mode ticks against a run of 60 shows the divide-by-sixty boundary.
- A reload value with both bytes nonzero, checked after ten ticks, shows that the high byte joins the count.

Directed cases cover the following:
- Keepalive from an enabled source against a disabled one.
- Each output enable alone, against test mode.
- A forced expiry.
- Writing 1 to the zero flag.
- Keepalive after expiry.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   // register offsets from REG_BASE; the order is the host's address map
   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_CFG  = 2'd1,
      SEL_RLO  = 2'd2,
      SEL_RHI  = 2'd3
   } reg_sel_e;

   // control bit positions
   localparam int unsigned CB_FORCE = 1;
   localparam int unsigned CB_ZERO  = 0;
   // configuration bit positions
   localparam int unsigned FB_SEC  = 7;
   localparam int unsigned FB_KRST = 6;
   localparam int unsigned FB_TMO  = 5;
   localparam int unsigned FB_PWR  = 4;

   // keepalive source enables, same order as control bits 7:4
   typedef struct packed {
      logic cir;
      logic mouse;
      logic kbd;
      logic gp;
   } wd_src_t;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
   parameter int unsigned DIV = 60
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic sec_tick,
   input  logic use_sec,
   output logic unit_tick
);
   generate
      if (DIV > 1) begin : g_div
         localparam int unsigned PW = $clog2(DIV);
         logic [PW-1:0] pcnt_q;
         logic          wrap;

         assign wrap = (pcnt_q == PW'(DIV - 1));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pcnt_q <= '0;
            end else if (clr) begin
               pcnt_q <= '0;
            end else if (sec_tick && !use_sec) begin
               pcnt_q <= wrap ? '0 : pcnt_q + PW'(1);
            end
         end

         assign unit_tick = use_sec ? sec_tick : (sec_tick & wrap);
      end else begin : g_nodiv
         assign unit_tick = sec_tick;
      end
   endgenerate
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             keep,
   input  logic             tick,
   input  logic             force_exp,
   output logic [CNT_W-1:0] count,
   output logic             running,
   output logic             hit
);
   logic at_one;

   assign at_one = (count == CNT_W'(1));
   // forced expiry first, then host load, then keepalive, then tick
   assign hit = force_exp | (running & tick & at_one & ~load & ~keep);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count   <= '0;
         running <= 1'b0;
      end else if (force_exp) begin
         count   <= '0;
         running <= 1'b0;
      end else if (load) begin
         count   <= load_val;
         running <= (load_val != '0);
      end else if (running && keep) begin
         count <= reload_val;
      end else if (running && tick) begin
         count <= count - CNT_W'(1);
         if (at_one) running <= 1'b0;
      end
   end
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
   parameter int unsigned LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic pulse
);
   localparam int unsigned CW = $clog2(LEN + 1);
   logic [CW-1:0] left_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (start) begin
         left_q <= CW'(LEN);
      end else if (left_q != '0) begin
         left_q <= left_q - CW'(1);
      end
   end

   assign pulse = (left_q != '0);
endmodule

// File: rtl/wdog_dual_unit.sv
module wdog_dual_unit
   import wdog_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned REG_BASE   = 8'h71,
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned MIN_DIV    = 60,
   parameter int unsigned RST_CYCLES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [7:0]        wr_data,
   output logic [7:0]        rd_data,
   input  logic              sec_tick,
   input  logic              gp_read,
   input  logic              cir_irq,
   input  logic              mouse_irq,
   input  logic              kbd_irq,
   output logic              kbd_rst_o,
   output logic              pwr_rst_o,
   output logic              tmo_evt_o,
   output logic [CNT_W-1:0]  count_o,
   output logic              running_o
);
   localparam int unsigned NREG = 4;
   localparam int unsigned NRST = 2;

   // elaboration-time parameter checks
   generate
      if (CNT_W != 8 && CNT_W != 16) begin : g_bad_w
         $error("CNT_W must be 8 or 16");
      end
      if (RST_CYCLES < 1) begin : g_bad_len
         $error("RST_CYCLES must be at least 1");
      end
      if (MIN_DIV < 1) begin : g_bad_div
         $error("MIN_DIV must be at least 1");
      end
      if (ADDR_W < 3) begin : g_bad_aw
         $error("ADDR_W too small");
      end
   endgenerate

   // address decode
   logic [ADDR_W-1:0] ofs;
   logic              acc_ok;
   reg_sel_e          sel;
   logic              wr_ctrl, wr_cfg, wr_rlo, wr_rhi;

   assign ofs     = addr - ADDR_W'(REG_BASE);
   assign acc_ok  = (ofs < ADDR_W'(NREG));
   assign sel     = reg_sel_e'(ofs[1:0]);
   assign wr_ctrl = wr_en & acc_ok & (sel == SEL_CTRL);
   assign wr_cfg  = wr_en & acc_ok & (sel == SEL_CFG);
   assign wr_rlo  = wr_en & acc_ok & (sel == SEL_RLO);
   assign wr_rhi  = wr_en & acc_ok & (sel == SEL_RHI);

   // register state
   wd_src_t    src_en_q;
   logic       force_q;
   logic       zero_q;
   logic [7:0] cfg_q;
   logic [7:0] rlo_q;
   logic [7:0] rhi_q;
   logic       hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_en_q <= '0;
         force_q  <= 1'b0;
         zero_q   <= 1'b0;
         cfg_q    <= '0;
         rlo_q    <= '0;
      end else begin
         if (wr_ctrl) src_en_q <= wd_src_t'(wr_data[7:4]);
         if (hit)
            force_q <= 1'b0;
         else if (wr_ctrl)
            force_q <= wr_data[CB_FORCE];
         if (hit)
            zero_q <= 1'b1;
         else if (wr_ctrl && !wr_data[CB_ZERO])
            zero_q <= 1'b0;
         if (wr_cfg) cfg_q <= wr_data;
         if (wr_rlo) rlo_q <= wr_data;
      end
   end

   // reload width variant
   logic [CNT_W-1:0] reload_val;
   logic [CNT_W-1:0] ld_val;
   logic             ld_en;

   generate
      if (CNT_W == 16) begin : g_wide
         always_ff @(posedge clk) begin
            if (!rst_n)
               rhi_q <= '0;
            else if (wr_rhi)
               rhi_q <= wr_data;
         end
         assign reload_val = {rhi_q, rlo_q};
         assign ld_en      = wr_rlo | wr_rhi;
         assign ld_val     = wr_rhi ? {wr_data, rlo_q} : {rhi_q, wr_data};
      end else begin : g_narrow
         assign rhi_q      = '0;
         assign reload_val = rlo_q;
         assign ld_en      = wr_rlo;
         assign ld_val     = wr_data;
      end
   endgenerate

   // keepalive
   wd_src_t act;
   logic    keep;

   assign act.cir   = cir_irq;
   assign act.mouse = mouse_irq;
   assign act.kbd   = kbd_irq;
   assign act.gp    = gp_read;
   assign keep      = |(src_en_q & act);

   // time base and counter
   logic unit_tick;
   logic pre_clr;

   assign pre_clr = ld_en | (running_o & keep) | force_q;

   wdog_prescale #(.DIV(MIN_DIV)) u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (pre_clr),
      .sec_tick  (sec_tick),
      .use_sec   (cfg_q[FB_SEC]),
      .unit_tick (unit_tick)
   );

   wdog_count #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (ld_en),
      .load_val   (ld_val),
      .reload_val (reload_val),
      .keep       (keep),
      .tick       (unit_tick),
      .force_exp  (force_q),
      .count      (count_o),
      .running    (running_o),
      .hit        (hit)
   );

   // expiry outputs
   logic [NRST-1:0] rst_start;
   logic [NRST-1:0] rst_pulse;

   assign rst_start[0] = hit & cfg_q[FB_KRST];
   assign rst_start[1] = hit & cfg_q[FB_PWR];

   generate
      for (genvar gi = 0; gi < NRST; gi++) begin : g_rst
         wdog_pulse #(.LEN(RST_CYCLES)) u_pulse (
            .clk   (clk),
            .rst_n (rst_n),
            .start (rst_start[gi]),
            .pulse (rst_pulse[gi])
         );
      end
   endgenerate

   assign kbd_rst_o = rst_pulse[0];
   assign pwr_rst_o = rst_pulse[1];

   always_ff @(posedge clk) begin
      if (!rst_n)
         tmo_evt_o <= 1'b0;
      else
         tmo_evt_o <= hit & cfg_q[FB_TMO];
   end

   // read mux
   always_comb begin
      rd_data = '0;
      if (acc_ok) begin
         case (sel)
            SEL_CTRL: rd_data = {src_en_q, 2'b00, force_q, zero_q};
            SEL_CFG:  rd_data = cfg_q;
            SEL_RLO:  rd_data = rlo_q;
            SEL_RHI:  rd_data = rhi_q;
            default:  rd_data = '0;
         endcase
      end
   end
endmodule

// File: rtl/wdog_dual_unit_chk.sv
module wdog_dual_unit_chk #(
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned RST_CYCLES = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hit,
   input logic             zero_q,
   input logic             force_q,
   input logic             ld_en,
   input logic [CNT_W-1:0] ld_val,
   input logic [CNT_W-1:0] count_o,
   input logic             running_o,
   input logic             kbd_rst_o,
   input logic             tmo_evt_o
);
   localparam int unsigned LW = $clog2(RST_CYCLES + 1) + 1;
   logic [LW-1:0] hi_len;

   always_ff @(posedge clk) begin
      if (!rst_n || hit)
         hi_len <= '0;
      else if (kbd_rst_o)
         hi_len <= hi_len + LW'(1);
      else
         hi_len <= '0;
   end

   assert_load_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && !force_q) |=> (count_o == $past(ld_val)));

   assert_flag_on_expiry_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> zero_q);

   assert_rst_after_expiry_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(kbd_rst_o) |-> $past(hit));

   assert_rst_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
      kbd_rst_o |-> (hi_len < LW'(RST_CYCLES)));

   assert_evt_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_evt_o |=> !tmo_evt_o);

   assert_force_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      force_q |=> !force_q);

   assert_stopped_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!running_o && !ld_en && !force_q) |=> $stable(count_o));
endmodule

bind wdog_dual_unit wdog_dual_unit_chk #(
   .CNT_W      (CNT_W),
   .RST_CYCLES (RST_CYCLES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .hit       (hit),
   .zero_q    (zero_q),
   .force_q   (force_q),
   .ld_en     (ld_en),
   .ld_val    (ld_val),
   .count_o   (count_o),
   .running_o (running_o),
   .kbd_rst_o (kbd_rst_o),
   .tmo_evt_o (tmo_evt_o)
);

// File: tb/wdog_dual_unit_test.sv
module wdog_dual_unit_test;
   localparam int unsigned LEN = 4;
   localparam logic [7:0] A_CTRL = 8'h71;
   localparam logic [7:0] A_CFG  = 8'h72;
   localparam logic [7:0] A_RLO  = 8'h73;
   localparam logic [7:0] A_RHI  = 8'h74;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_data = '0;
   logic [7:0]  rd_data;
   logic        sec_tick = 1'b0;
   logic        gp_read = 1'b0;
   logic        cir_irq = 1'b0;
   logic        mouse_irq = 1'b0;
   logic        kbd_irq = 1'b0;
   logic        kbd_rst_o, pwr_rst_o, tmo_evt_o, running_o;
   logic [15:0] count_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   wdog_dual_unit #(.RST_CYCLES(LEN)) uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .sec_tick(sec_tick), .gp_read(gp_read), .cir_irq(cir_irq),
      .mouse_irq(mouse_irq), .kbd_irq(kbd_irq), .kbd_rst_o(kbd_rst_o),
      .pwr_rst_o(pwr_rst_o), .tmo_evt_o(tmo_evt_o), .count_o(count_o),
      .running_o(running_o)
   );

   typedef struct packed {
      logic [7:0]  cfg;
      logic [15:0] rl;
      logic [7:0]  tk;
      logic [15:0] ec;
      logic        es;
   } vec_t;

   localparam vec_t VEC [9] = '{
      '{8'h80, 16'd5,      8'd3,   16'd2,   1'b0},
      '{8'h80, 16'd1,      8'd1,   16'd0,   1'b1},
      '{8'h80, 16'd2,      8'd5,   16'd0,   1'b1},
      '{8'h80, 16'd12,     8'd11,  16'd1,   1'b0},
      '{8'h80, 16'h0102,   8'd10,  16'd248, 1'b0},
      '{8'h00, 16'd3,      8'd59,  16'd3,   1'b0},
      '{8'h00, 16'd3,      8'd60,  16'd2,   1'b0},
      '{8'h00, 16'd2,      8'd120, 16'd0,   1'b1},
      '{8'h80, 16'd0,      8'd4,   16'd0,   1'b0}
   };

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      addr = a; wr_data = d; wr_en = 1'b1;
      step();
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] v);
      addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         sec_tick = 1'b1;
         step();
         sec_tick = 1'b0;
      end
   endtask

   task automatic arm(input logic [7:0] ctrl, input logic [7:0] cfg, input logic [15:0] rl);
      wr(A_CTRL, ctrl);
      wr(A_CFG, cfg);
      wr(A_RHI, rl[15:8]);
      wr(A_RLO, rl[7:0]);
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      int n;
      repeat (3) step();
      rst_n = 1'b1;
      step();

      // R1: reset state
      rd(A_CTRL, v); chk("R1 reset ctrl", v, 8'h00);
      rd(A_CFG, v);  chk("R1 reset cfg", v, 8'h00);
      rd(A_RHI, v);  chk("R1 reset hi", v, 8'h00);
      chk("R1 reset count", count_o, 0);
      chk("R1 reset outputs", {kbd_rst_o, pwr_rst_o, tmo_evt_o, running_o}, 0);

      // R1: readback
      wr(A_CFG, 8'h5A); rd(A_CFG, v); chk("R1 cfg readback", v, 8'h5A);
      wr(A_RLO, 8'hC3); rd(A_RLO, v); chk("R1 lo readback", v, 8'hC3);
      wr(A_RLO, 8'h00);

      // R2 R3 R4 R6: vector table
      foreach (VEC[i]) begin
         arm(8'h00, VEC[i].cfg, VEC[i].rl);
         tick(int'(VEC[i].tk));
         chk($sformatf("R3/R4 vec%0d count", i), count_o, VEC[i].ec);
         rd(A_CTRL, v);
         chk($sformatf("R6 vec%0d flag", i), v[0], VEC[i].es);
         chk($sformatf("R2 vec%0d running", i), running_o,
             (VEC[i].ec != 0) ? 1 : 0);
      end

      // R6: flag write semantics
      arm(8'h00, 8'h80, 16'd1); tick(1);
      wr(A_CTRL, 8'h01); rd(A_CTRL, v); chk("R6 write1 keeps flag", v, 8'h01);
      wr(A_CTRL, 8'h00); rd(A_CTRL, v); chk("R6 write0 clears flag", v, 8'h00);
      wr(A_CTRL, 8'h01); rd(A_CTRL, v); chk("R6 write1 no set", v, 8'h00);

      // R5: keepalive enabled vs disabled
      arm(8'h10, 8'h80, 16'd5); tick(3);
      chk("R5 pre count", count_o, 3'd2);
      gp_read = 1'b1; step(); gp_read = 1'b0;
      chk("R5 gameport reload", count_o, 5);
      tick(2);
      cir_irq = 1'b1; step(); cir_irq = 1'b0;
      chk("R5 disabled source ignored", count_o, 3);
      wr(A_CTRL, 8'hD0);
      cir_irq = 1'b1; step(); cir_irq = 1'b0;
      chk("R5 cir reload", count_o, 5);

      // R7: reset pulses
      arm(8'h00, 8'hD0, 16'd1); tick(1);
      chk("R7 kbd reset high", kbd_rst_o, 1);
      chk("R7 pwr reset high", pwr_rst_o, 1);
      chk("R8 no event when disabled", tmo_evt_o, 0);
      n = 1;
      while (kbd_rst_o && n < 20) begin step(); if (kbd_rst_o) n++; end
      chk("R7 pulse length", n, LEN);

      // R8: timeout event
      arm(8'h00, 8'hA0, 16'd1); tick(1);
      chk("R8 event high", tmo_evt_o, 1);
      chk("R7 kbd stays low", kbd_rst_o, 0);
      step();
      chk("R8 event one cycle", tmo_evt_o, 0);

      // R9: test mode
      arm(8'h00, 8'h80, 16'd1); tick(1);
      chk("R9 no outputs", {kbd_rst_o, pwr_rst_o, tmo_evt_o}, 0);
      rd(A_CTRL, v); chk("R9 flag set", v[0], 1);

      // R10: forced expiry
      arm(8'h00, 8'hC0, 16'd50);
      wr(A_CTRL, 8'h02);
      rd(A_CTRL, v); chk("R10 force pending", v, 8'h02);
      step();
      rd(A_CTRL, v); chk("R10 force self-clear and flag", v, 8'h01);
      chk("R10 count zero", count_o, 0);
      chk("R10 reset pulse", kbd_rst_o, 1);

      // R11: keepalive while stopped
      repeat (LEN + 1) step();
      wr(A_CTRL, 8'h10);
      gp_read = 1'b1; step(); gp_read = 1'b0;
      tick(2);
      chk("R11 stopped count", count_o, 0);
      chk("R11 stays stopped", running_o, 0);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule